// File: doc/BRIEF.md
# Protection Entry Lock Bank

This block holds the register state for a set of physical-memory-protection entries and enforces their lock rule. Each entry owns an 8-bit configuration byte and an address register. Software reaches them through one write port and one combinational read port. Configuration bytes are packed several to a word, and address registers are reached one per index. The block does no address matching and no permission checking. It stores the registers, drops writes that a lock forbids, and reports each entry's lock state and whether its checks bind machine mode.

Once an entry's lock bit is set, the lock can only be cleared by a reset of the hart. While the lock is set, writes to that entry's configuration byte and to its address register leave them unchanged. A locked entry in top-of-range mode uses the address register below it as its lower bound. For that reason its lock also freezes that lower address register, even when the lower entry is not locked itself. Downstream matching logic uses the machine-mode flag to apply a locked, active entry to machine-mode accesses. Supervisor and user modes get access only where entries grant it.

Top module: `pmp_lock_bank`

## Requirements
- R1: After reset (synchronous, active low), every configuration byte reads 0 (lock clear, mode OFF) and every address register reads 0.
- R2: Configuration byte layout: bit 0 R, bit 1 W, bit 2 X, bits 4:3 mode (0 OFF, 1 TOR, 2 NA4, 3 NAPOT), bits 6:5 reserved and always read 0, bit 7 lock. Entry 4k+j sits in bits 8j+7:8j of configuration word k.
- R3: A write to an unlocked register is visible on the read port from the cycle after the write. The read port is combinational.
- R4: A write to a configuration word leaves every locked byte in that word unchanged and updates the unlocked bytes.
- R5: A write to the address register of a locked entry leaves it unchanged.
- R6: If entry i+1 is locked with mode TOR, writes to address register i are dropped. If entry i+1 is locked in any other mode, those writes take effect.
- R7: Entry 0 locked in TOR mode protects only its own registers. Entry 1's address register stays writable.
- R8: No write can clear a set lock bit. Only reset clears it.
- R9: Lock checks use the state before the write, so a single write that sets the lock together with other fields stores all of them.
- R10: lock_o[i] equals entry i's lock bit. m_enforce_o[i] is 1 exactly when entry i is locked and its mode is not OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hart reset |
| wr_en | input | 1 | Write strobe |
| wr_is_addr | input | 1 | 1: write an address register; 0: write a configuration word |
| wr_idx | input | IDX_W | Entry index (address) or word index (configuration) |
| wr_data | input | XLEN | Write data |
| rd_is_addr | input | 1 | 1: read an address register; 0: read a configuration word |
| rd_idx | input | IDX_W | Read index, same meaning as wr_idx |
| rd_data | output | XLEN | Combinational read data |
| lock_o | output | N_ENTRIES | Per-entry lock state |
| m_enforce_o | output | N_ENTRIES | Per-entry flag: checks also apply to machine mode |

## Verification
The hardest case to reach is an unlocked address register that still refuses writes because the entry above it is locked in TOR mode. Locks are sticky, so random traffic soon freezes most of the bank and then stops exercising it. The stimulus writes a known value to the lower address first, then locks the upper entry in TOR mode, then tries to overwrite the lower address. A contrasting entry is locked in NA4 mode. A random phase sets a lock bit in only about one byte in eight, so that it stays useful for longer, and it passes through a mid-run reset.

// File: rtl/pmp_lock_pkg.sv
// Shared field positions and mode encoding for the protection entry bank.
// Assumes 8-bit configuration bytes; reserved bits are never stored.
package pmp_lock_pkg;
    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    localparam int          CFG_W    = 8;
    localparam int          LOCK_BIT = 7;
    localparam int          MODE_LO  = 3;
    localparam logic [7:0]  CFG_KEEP = 8'h9F;   // bits 6:5 forced to zero
endpackage

// File: rtl/pmp_entry_regs.sv
// One protection entry: configuration byte and address register.
// Assumes the caller has already gated the write enables with the lock rule.
module pmp_entry_regs
    import pmp_lock_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             addr_we,
    input  logic [AW-1:0]    addr_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic [AW-1:0]    addr_q
);
    // Configuration byte, reserved bits dropped on write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata & CFG_KEEP;
    end

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_we) addr_q <= addr_wdata;
    end

    // R4
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[LOCK_BIT] |=> $stable(cfg_q));
    // R5
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[LOCK_BIT] |=> $stable(addr_q));
    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[LOCK_BIT] |=> cfg_q[LOCK_BIT]);
    // R2
    resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[6:5] == 2'b00);
endmodule

// File: rtl/pmp_wr_gate.sv
// Lock rule: decides from the current (pre-write) state which registers accept writes.
// Assumes entry 0 has no lower neighbour; TOR lock on the top entry protects below it.
module pmp_wr_gate
    import pmp_lock_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]      lock_i,
    input  logic [N-1:0][1:0] mode_i,
    output logic [N-1:0]      cfg_open,
    output logic [N-1:0]      addr_open,
    output logic [N-1:0]      m_enforce
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        logic above_tor_lock;
        if (i < N - 1) begin : g_nbr
            // Upper neighbour locked in TOR mode pins this address.
            always_comb above_tor_lock = lock_i[i+1] && (mode_i[i+1] == AM_TOR);
        end else begin : g_top
            always_comb above_tor_lock = 1'b0;
        end
        // Per-entry write permission and machine-mode flag.
        always_comb begin
            cfg_open[i]  = !lock_i[i];
            addr_open[i] = !lock_i[i] && !above_tor_lock;
            m_enforce[i] = lock_i[i] && (mode_i[i] != AM_OFF);
        end
    end
endmodule

// File: rtl/pmp_lock_bank.sv
// Bank of protection entries with packed configuration words and lock enforcement.
// Assumes N_ENTRIES is a multiple of XLEN/8 and at least 2; reads are combinational.
module pmp_lock_bank
    import pmp_lock_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int XLEN      = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_is_addr,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [XLEN-1:0]      wr_data,
    input  logic                 rd_is_addr,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [XLEN-1:0]      rd_data,
    output logic [N_ENTRIES-1:0] lock_o,
    output logic [N_ENTRIES-1:0] m_enforce_o
);
    localparam int CPW       = XLEN / CFG_W;
    localparam int CFG_WORDS = N_ENTRIES / CPW;

    logic [N_ENTRIES-1:0][CFG_W-1:0] cfg_q;
    logic [N_ENTRIES-1:0][XLEN-1:0]  addr_q;
    logic [N_ENTRIES-1:0][1:0]       mode_v;
    logic [N_ENTRIES-1:0]            lock_v, cfg_open, addr_open;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        logic cfg_we, addr_we;
        // Field extraction for the gate.
        always_comb begin
            lock_v[i] = cfg_q[i][LOCK_BIT];
            mode_v[i] = cfg_q[i][MODE_LO+1:MODE_LO];
        end
        // Write decode, masked per byte by the lock rule.
        always_comb begin
            cfg_we  = wr_en && !wr_is_addr && (wr_idx == IDX_W'(i / CPW)) && cfg_open[i];
            addr_we = wr_en &&  wr_is_addr && (wr_idx == IDX_W'(i)) && addr_open[i];
        end
        pmp_entry_regs #(.AW(XLEN)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we),
            .cfg_wdata  (wr_data[CFG_W*(i%CPW) +: CFG_W]),
            .addr_we    (addr_we),
            .addr_wdata (wr_data),
            .cfg_q      (cfg_q[i]),
            .addr_q     (addr_q[i])
        );
    end

    pmp_wr_gate #(.N(N_ENTRIES)) u_gate (
        .lock_i    (lock_v),
        .mode_i    (mode_v),
        .cfg_open  (cfg_open),
        .addr_open (addr_open),
        .m_enforce (m_enforce_o)
    );

    // Status outputs.
    always_comb lock_o = lock_v;

    // Read mux: address register or packed configuration word.
    always_comb begin
        rd_data = '0;
        if (rd_is_addr) begin
            rd_data = addr_q[rd_idx];
        end else begin
            for (int w = 0; w < CFG_WORDS; w++)
                if (rd_idx == IDX_W'(w))
                    for (int b = 0; b < CPW; b++)
                        rd_data[CFG_W*b +: CFG_W] = cfg_q[w*CPW + b];
        end
    end

    for (genvar i = 0; i < N_ENTRIES - 1; i++) begin : g_tor_chk
        // R6
        below_addr_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_v[i+1] && mode_v[i+1] == AM_TOR) |=> $stable(addr_q[i]));
    end
endmodule

// File: tb/pmp_lock_bank_test.sv
module pmp_lock_bank_test;
    localparam int N = 16;
    localparam int XL = 32;
    localparam int IW = 4;
    localparam int CPW = 4;
    localparam int WORDS = N / CPW;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, wr_is_addr = 0, rd_is_addr = 0;
    logic [IW-1:0] wr_idx = '0, rd_idx = '0;
    logic [XL-1:0] wr_data = '0, rd_data;
    logic [N-1:0] lock_o, m_enforce_o;

    int total = 0, bad = 0;
    logic [7:0]  mcfg [N];
    logic [XL-1:0] maddr [N];

    always #4 clk = ~clk;

    pmp_lock_bank #(.N_ENTRIES(N), .XLEN(XL)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_addr(wr_is_addr),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_is_addr(rd_is_addr),
        .rd_idx(rd_idx), .rd_data(rd_data), .lock_o(lock_o), .m_enforce_o(m_enforce_o));

    task automatic chk(string tag, logic [XL-1:0] act, logic [XL-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [XL-1:0] exp_word(int w);
        logic [XL-1:0] r = '0;
        for (int b = 0; b < CPW; b++) r[8*b +: 8] = mcfg[w*CPW + b];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_lock();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = mcfg[i][7];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_menf();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = mcfg[i][7] && (mcfg[i][4:3] != 2'd0);
        return r;
    endfunction

    // Reference model: decide from pre-write state, then apply.
    task automatic model_write(bit is_addr, int idx, logic [XL-1:0] d);
        if (is_addr) begin
            bit blocked = mcfg[idx][7];
            if (idx < N - 1 && mcfg[idx+1][7] && mcfg[idx+1][4:3] == 2'd1) blocked = 1;
            if (!blocked) maddr[idx] = d;
        end else begin
            for (int b = 0; b < CPW; b++)
                if (!mcfg[idx*CPW + b][7]) mcfg[idx*CPW + b] = d[8*b +: 8] & 8'h9F;
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin mcfg[i] = 8'h00; maddr[i] = '0; end
    endtask

    task automatic do_write(bit is_addr, int idx, logic [XL-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_is_addr = is_addr; wr_idx = IW'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model_write(is_addr, idx, d);
    endtask

    task automatic rd(bit is_addr, int idx, output logic [XL-1:0] v);
        rd_is_addr = is_addr; rd_idx = IW'(idx);
        #1 v = rd_data;
    endtask

    task automatic check_all(string tag);
        logic [XL-1:0] v;
        for (int i = 0; i < N; i++) begin rd(1, i, v); chk(tag, v, maddr[i]); end
        for (int w = 0; w < WORDS; w++) begin rd(0, w, v); chk(tag, v, exp_word(w)); end
        chk({tag, "/R10 lock"}, XL'(lock_o), XL'(exp_lock()));
        chk({tag, "/R10 menf"}, XL'(m_enforce_o), XL'(exp_menf()));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        model_reset();
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [XL-1:0] v;
        void'($urandom(32'd1357));
        model_reset();
        do_reset();
        check_all("R1");

        // R2 / R3: reserved bits and packing, unlocked writes land
        do_write(0, 1, 32'h1F7F600B);
        rd(0, 1, v); chk("R2 packing", v, 32'h1F1F000B);
        do_write(1, 2, 32'h0000_1111);
        rd(1, 2, v); chk("R3 addr write", v, 32'h0000_1111);

        // R9: lock + fields in one write
        do_write(0, 0, 32'h0000008D);
        rd(0, 0, v); chk("R9 lock with fields", v, 32'h0000008D);
        chk("R10 lock0", XL'(lock_o[0]), 1);
        chk("R10 menf0", XL'(m_enforce_o[0]), 1);

        // R4: neighbours update, locked byte kept
        do_write(0, 0, 32'h07070700);
        rd(0, 0, v); chk("R4 byte mask", v, 32'h0707078D);

        // R5 / R7
        do_write(1, 0, 32'h1234);
        rd(1, 0, v); chk("R5 locked addr", v, 32'h0);
        do_write(1, 1, 32'hABCD);
        rd(1, 1, v); chk("R7 entry0 TOR", v, 32'hABCD);

        // R8: clearing the lock has no effect
        do_write(0, 0, 32'h07070700);
        chk("R8 lock kept", XL'(lock_o[0]), 1);
        rd(0, 0, v); chk("R8 cfg kept", v, 32'h0707078D);

        // R6: entry 3 TOR lock pins addr 2; entry 6 NA4 lock does not pin addr 5
        do_write(0, 0, 32'h8807078D);
        do_write(1, 2, 32'h55);
        rd(1, 2, v); chk("R6 TOR pins below", v, 32'h0000_1111);
        rd(1, 3, v); chk("R6 own addr", v, 32'h0);
        do_write(0, 1, 32'h1F90000B);
        do_write(1, 5, 32'h2222);
        rd(1, 5, v); chk("R6 NA4 no pin", v, 32'h2222);
        chk("R10 menf6", XL'(m_enforce_o[6]), 1);

        // R10: lock with mode OFF
        do_write(0, 2, 32'h00000080);
        chk("R10 lock8", XL'(lock_o[8]), 1);
        chk("R10 menf8 off", XL'(m_enforce_o[8]), 0);
        check_all("R6 state");

        // R8 / R1: reset clears locks
        do_reset();
        check_all("R8 reset");

        // Random phase
        for (int k = 0; k < 400; k++) begin
            bit ia = ($urandom % 2) == 1;
            int idx = ia ? int'($urandom % N) : int'($urandom % WORDS);
            logic [XL-1:0] d;
            if (ia) d = $urandom;
            else for (int b = 0; b < CPW; b++)
                d[8*b +: 8] = 8'($urandom & 32'h7F) | ((($urandom % 8) == 0) ? 8'h80 : 8'h00);
            do_write(ia, idx, d);
            chk("R10 rand lock", XL'(lock_o), XL'(exp_lock()));
            if (k % 25 == 24) check_all("R4 rand");
            if (k == 200) begin do_reset(); check_all("R1 rand reset"); end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule